// File: doc/BRIEF.md
# Double-Indirection Memory Fetch Engine

This block is a small bus master that follows one pointer in memory on behalf of software. Software programs a base address and an offset through a register interface on an AXI4-Lite slave port. Writing the offset launches a sequence. The engine adds the two values to form a first address and reads one word there through a read-only AXI4 master port. It then uses the returned word as the address of a second read, and stores the second word in a result register.

Software learns the outcome from a status register. That register shows a busy bit while the two reads are in flight. When the sequence ends, either a done bit or an error bit is set. Only one master read is ever outstanding, and every read is a single beat. A failed bus response stops the chain and leaves the previous result in place.

Top module: `ptrfetch_engine`

## Requirements
- R1: Word 0x0 (base) and word 0x4 (offset) are read/write 32-bit registers. Bit n of the write strobe enables byte n. A slave write or read whose address bits [1:0] are not zero completes with OKAY but changes nothing (reads return 0).
- R2: The first master read address is base plus offset, modulo 2^32, using the register values at the moment the sequence starts.
- R3: The second master read address is the data word returned by the first read.
- R4: Word 0x8 returns the data of the last successful second read. Slave writes to 0x8 and 0xC have no effect.
- R5: An accepted write to 0x4 while the engine is idle starts a sequence. While a sequence is busy, such a write updates the offset register but issues no extra master read and does not restart the sequence.
- R6: ARVALID, once high, stays high with an unchanged ARADDR until ARREADY is seen. ARVALID is never high while data is awaited. RREADY is high only while data is awaited.
- R7: Every master read carries ARLEN=0, ARSIZE=3'b010 (4 bytes), ARBURST=2'b01 (incrementing) and ARID=0.
- R8: An RRESP other than 2'b00 on either read ends the sequence. No further read is issued, the error bit is set and the result register is unchanged.
- R9: Word 0xC is status: bit 0 busy (from start until the final response), bit 1 done (second read succeeded), bit 2 error. Done and error both clear when a sequence starts.
- R10: After reset, ARVALID, RREADY and the slave BVALID and RVALID outputs are low, and all four registers read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_awaddr | input | 4 | Slave write address |
| s_awvalid | input | 1 | Slave write address valid |
| s_awready | output | 1 | Slave write address ready |
| s_wdata | input | 32 | Slave write data |
| s_wstrb | input | 4 | Slave write byte strobes |
| s_wvalid | input | 1 | Slave write data valid |
| s_wready | output | 1 | Slave write data ready |
| s_bresp | output | 2 | Slave write response (always OKAY) |
| s_bvalid | output | 1 | Slave write response valid |
| s_bready | input | 1 | Slave write response ready |
| s_araddr | input | 4 | Slave read address |
| s_arvalid | input | 1 | Slave read address valid |
| s_arready | output | 1 | Slave read address ready |
| s_rdata | output | 32 | Slave read data |
| s_rresp | output | 2 | Slave read response (always OKAY) |
| s_rvalid | output | 1 | Slave read data valid |
| s_rready | input | 1 | Slave read data ready |
| m_arid | output | 4 | Master read ID |
| m_araddr | output | 32 | Master read address |
| m_arlen | output | 8 | Master burst length |
| m_arsize | output | 3 | Master beat size |
| m_arburst | output | 2 | Master burst type |
| m_arvalid | output | 1 | Master read address valid |
| m_arready | input | 1 | Master read address ready |
| m_rdata | input | 32 | Master read data |
| m_rresp | input | 2 | Master read response |
| m_rvalid | input | 1 | Master read data valid |
| m_rready | output | 1 | Master read data ready |

## Verification
Two functions can coincide: a software write to the offset register that would start a sequence, and a sequence that is already in flight. The bench holds the memory model's ARREADY low for several cycles after a launch. While the engine waits, it writes a new offset and reads the status. The scoreboard expects exactly two address handshakes, carrying the original addresses, and flags any additional one. It also requires the original result, together with busy set during the wait and the new offset value stored.

// File: rtl/ptrfetch_pkg.sv
package ptrfetch_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_AR1  = 3'd1,
    ST_R1   = 3'd2,
    ST_AR2  = 3'd3,
    ST_R2   = 3'd4,
    ST_DONE = 3'd5
  } seq_state_e;

  localparam logic [1:0] RESP_OKAY  = 2'b00;
  localparam logic [1:0] BURST_INCR = 2'b01;

  localparam logic [1:0] IDX_BASE   = 2'd0;
  localparam logic [1:0] IDX_OFFSET = 2'd1;
  localparam logic [1:0] IDX_RESULT = 2'd2;
  localparam logic [1:0] IDX_STATUS = 2'd3;

endpackage

// File: rtl/ptrfetch_lite_slv.sv
module ptrfetch_lite_slv
  import ptrfetch_pkg::*;
#(
  parameter  int WORD_W  = 32,
  localparam int STRB_W  = WORD_W / 8,
  localparam int IDX_LSB = $clog2(STRB_W),
  localparam int S_AW    = IDX_LSB + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [S_AW-1:0]   s_awaddr,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [WORD_W-1:0] s_wdata,
  input  logic [STRB_W-1:0] s_wstrb,
  input  logic              s_wvalid,
  output logic              s_wready,
  output logic [1:0]        s_bresp,
  output logic              s_bvalid,
  input  logic              s_bready,
  input  logic [S_AW-1:0]   s_araddr,
  input  logic              s_arvalid,
  output logic              s_arready,
  output logic [WORD_W-1:0] s_rdata,
  output logic [1:0]        s_rresp,
  output logic              s_rvalid,
  input  logic              s_rready,
  output logic              wr_en,
  output logic [1:0]        wr_idx,
  output logic [WORD_W-1:0] wr_data,
  output logic [STRB_W-1:0] wr_strb,
  output logic [1:0]        rd_idx,
  input  logic [WORD_W-1:0] rd_word
);

  logic              bvalid_q, bvalid_d, bvalid_en;
  logic              rvalid_q, rvalid_d, rvalid_en;
  logic [WORD_W-1:0] rdata_q, rdata_d;
  logic              wr_fire, rd_fire;
  logic              wr_aligned, rd_aligned;

  // A write is taken only when address and data arrive together
  assign wr_fire    = s_awvalid & s_wvalid & ~bvalid_q;
  assign rd_fire    = s_arvalid & ~rvalid_q;
  assign wr_aligned = (s_awaddr[IDX_LSB-1:0] == '0);
  assign rd_aligned = (s_araddr[IDX_LSB-1:0] == '0);

  assign s_awready = wr_fire;
  assign s_wready  = wr_fire;
  assign s_arready = ~rvalid_q;
  assign s_bvalid  = bvalid_q;
  assign s_bresp   = RESP_OKAY;
  assign s_rvalid  = rvalid_q;
  assign s_rresp   = RESP_OKAY;
  assign s_rdata   = rdata_q;

  assign wr_en   = wr_fire & wr_aligned;
  assign wr_idx  = s_awaddr[IDX_LSB+1:IDX_LSB];
  assign wr_data = s_wdata;
  assign wr_strb = s_wstrb;
  assign rd_idx  = s_araddr[IDX_LSB+1:IDX_LSB];

  always_comb begin
    bvalid_en = wr_fire | (bvalid_q & s_bready);
    bvalid_d  = wr_fire;
    rvalid_en = rd_fire | (rvalid_q & s_rready);
    rvalid_d  = rd_fire;
    rdata_d   = rd_aligned ? rd_word : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bvalid_q <= 1'b0;
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      if (bvalid_en) bvalid_q <= bvalid_d;
      if (rvalid_en) rvalid_q <= rvalid_d;
      if (rd_fire)   rdata_q  <= rdata_d;
    end
  end

endmodule

// File: rtl/ptrfetch_regs.sv
module ptrfetch_regs
  import ptrfetch_pkg::*;
#(
  parameter  int WORD_W = 32,
  localparam int STRB_W = WORD_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_idx,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [STRB_W-1:0] wr_strb,
  input  logic [1:0]        rd_idx,
  output logic [WORD_W-1:0] rd_word,
  input  logic              busy,
  input  logic              done,
  input  logic              error,
  input  logic [WORD_W-1:0] result,
  output logic [WORD_W-1:0] base,
  output logic [WORD_W-1:0] offset,
  output logic              start
);

  logic [WORD_W-1:0] base_q, offset_q;
  logic              start_q, start_d;
  logic              base_sel, offset_sel;

  assign base_sel   = wr_en & (wr_idx == IDX_BASE);
  assign offset_sel = wr_en & (wr_idx == IDX_OFFSET);

  for (genvar g = 0; g < STRB_W; g++) begin : g_byte
    logic base_en, offset_en;
    assign base_en   = base_sel & wr_strb[g];
    assign offset_en = offset_sel & wr_strb[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q[g*8 +: 8]   <= 8'h00;
        offset_q[g*8 +: 8] <= 8'h00;
      end else begin
        if (base_en)   base_q[g*8 +: 8]   <= wr_data[g*8 +: 8];
        if (offset_en) offset_q[g*8 +: 8] <= wr_data[g*8 +: 8];
      end
    end
  end

  // Launch one cycle later so the new offset is already held
  assign start_d = offset_sel & ~busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) start_q <= 1'b0;
    else        start_q <= start_d;
  end

  always_comb begin
    rd_word = '0;
    unique case (rd_idx)
      IDX_BASE:   rd_word = base_q;
      IDX_OFFSET: rd_word = offset_q;
      IDX_RESULT: rd_word = result;
      IDX_STATUS: rd_word[2:0] = {error, done, busy};
      default:    rd_word = '0;
    endcase
  end

  assign base   = base_q;
  assign offset = offset_q;
  assign start  = start_q;

endmodule

// File: rtl/ptrfetch_seq.sv
module ptrfetch_seq
  import ptrfetch_pkg::*;
#(
  parameter  int WORD_W = 32,
  parameter  int ID_W   = 4,
  localparam int STRB_W = WORD_W / 8,
  localparam logic [2:0] BEAT_SIZE = 3'($clog2(STRB_W))
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] base,
  input  logic [WORD_W-1:0] offset,
  output logic [ID_W-1:0]   m_arid,
  output logic [WORD_W-1:0] m_araddr,
  output logic [7:0]        m_arlen,
  output logic [2:0]        m_arsize,
  output logic [1:0]        m_arburst,
  output logic              m_arvalid,
  input  logic              m_arready,
  input  logic [WORD_W-1:0] m_rdata,
  input  logic [1:0]        m_rresp,
  input  logic              m_rvalid,
  output logic              m_rready,
  output logic [WORD_W-1:0] result,
  output logic              busy,
  output logic              done,
  output logic              error
);

  seq_state_e        state_q, state_d;
  logic [WORD_W-1:0] addr_q, addr_d;
  logic [WORD_W-1:0] result_q;
  logic              done_q, done_d, done_en;
  logic              err_q, err_d, err_en;
  logic              addr_en, res_en;
  logic              idle_like, go, resp_ok, first_ok, bad_beat;

  assign idle_like = (state_q == ST_IDLE) | (state_q == ST_DONE);
  assign go        = start & idle_like;
  assign resp_ok   = (m_rresp == RESP_OKAY);
  assign first_ok  = (state_q == ST_R1) & m_rvalid & resp_ok;
  assign res_en    = (state_q == ST_R2) & m_rvalid & resp_ok;
  assign bad_beat  = ((state_q == ST_R1) | (state_q == ST_R2)) & m_rvalid & ~resp_ok;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE, ST_DONE: state_d = start ? ST_AR1 : ST_IDLE;
      ST_AR1: if (m_arready) state_d = ST_R1;
      ST_R1:  if (m_rvalid)  state_d = resp_ok ? ST_AR2 : ST_IDLE;
      ST_AR2: if (m_arready) state_d = ST_R2;
      ST_R2:  if (m_rvalid)  state_d = resp_ok ? ST_DONE : ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    addr_en = go | first_ok;
    addr_d  = first_ok ? m_rdata : (base + offset);
    done_en = go | res_en;
    done_d  = res_en;
    err_en  = go | bad_beat;
    err_d   = bad_beat;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      addr_q   <= '0;
      result_q <= '0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (addr_en) addr_q   <= addr_d;
      if (res_en)  result_q <= m_rdata;
      if (done_en) done_q   <= done_d;
      if (err_en)  err_q    <= err_d;
    end
  end

  assign m_arvalid = (state_q == ST_AR1) | (state_q == ST_AR2);
  assign m_rready  = (state_q == ST_R1)  | (state_q == ST_R2);
  assign m_araddr  = addr_q;
  assign m_arid    = '0;
  assign m_arlen   = 8'd0;
  assign m_arsize  = BEAT_SIZE;
  assign m_arburst = BURST_INCR;

  assign result = result_q;
  assign busy   = ~idle_like;
  assign done   = done_q;
  assign error  = err_q;

endmodule

// File: rtl/ptrfetch_engine.sv
module ptrfetch_engine
  import ptrfetch_pkg::*;
#(
  parameter  int WORD_W  = 32,
  parameter  int ID_W    = 4,
  localparam int STRB_W  = WORD_W / 8,
  localparam int S_AW    = $clog2(STRB_W) + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [S_AW-1:0]   s_awaddr,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [WORD_W-1:0] s_wdata,
  input  logic [STRB_W-1:0] s_wstrb,
  input  logic              s_wvalid,
  output logic              s_wready,
  output logic [1:0]        s_bresp,
  output logic              s_bvalid,
  input  logic              s_bready,
  input  logic [S_AW-1:0]   s_araddr,
  input  logic              s_arvalid,
  output logic              s_arready,
  output logic [WORD_W-1:0] s_rdata,
  output logic [1:0]        s_rresp,
  output logic              s_rvalid,
  input  logic              s_rready,
  output logic [ID_W-1:0]   m_arid,
  output logic [WORD_W-1:0] m_araddr,
  output logic [7:0]        m_arlen,
  output logic [2:0]        m_arsize,
  output logic [1:0]        m_arburst,
  output logic              m_arvalid,
  input  logic              m_arready,
  input  logic [WORD_W-1:0] m_rdata,
  input  logic [1:0]        m_rresp,
  input  logic              m_rvalid,
  output logic              m_rready
);

  logic [1:0]        rst_sync_q;
  logic              rst_sync_n;
  logic              wr_en;
  logic [1:0]        wr_idx, rd_idx;
  logic [WORD_W-1:0] wr_data, rd_word;
  logic [STRB_W-1:0] wr_strb;
  logic [WORD_W-1:0] base_w, offset_w, result_w;
  logic              seq_start, busy_w, done_w, error_w;

  // Reset asserts at once and releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  ptrfetch_lite_slv #(.WORD_W(WORD_W)) u_slv (
    .clk(clk), .rst_n(rst_sync_n),
    .s_awaddr(s_awaddr), .s_awvalid(s_awvalid), .s_awready(s_awready),
    .s_wdata(s_wdata), .s_wstrb(s_wstrb), .s_wvalid(s_wvalid), .s_wready(s_wready),
    .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready),
    .s_araddr(s_araddr), .s_arvalid(s_arvalid), .s_arready(s_arready),
    .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rvalid(s_rvalid), .s_rready(s_rready),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .wr_strb(wr_strb),
    .rd_idx(rd_idx), .rd_word(rd_word)
  );

  ptrfetch_regs #(.WORD_W(WORD_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .wr_strb(wr_strb),
    .rd_idx(rd_idx), .rd_word(rd_word),
    .busy(busy_w), .done(done_w), .error(error_w), .result(result_w),
    .base(base_w), .offset(offset_w), .start(seq_start)
  );

  ptrfetch_seq #(.WORD_W(WORD_W), .ID_W(ID_W)) u_seq (
    .clk(clk), .rst_n(rst_sync_n),
    .start(seq_start), .base(base_w), .offset(offset_w),
    .m_arid(m_arid), .m_araddr(m_araddr), .m_arlen(m_arlen), .m_arsize(m_arsize),
    .m_arburst(m_arburst), .m_arvalid(m_arvalid), .m_arready(m_arready),
    .m_rdata(m_rdata), .m_rresp(m_rresp), .m_rvalid(m_rvalid), .m_rready(m_rready),
    .result(result_w), .busy(busy_w), .done(done_w), .error(error_w)
  );

endmodule

// File: rtl/ptrfetch_engine_chk.sv
module ptrfetch_engine_chk #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [WORD_W-1:0] base,
  input logic [WORD_W-1:0] offset,
  input logic [WORD_W-1:0] result,
  input logic              busy,
  input logic              done,
  input logic              error,
  input logic              arvalid,
  input logic              arready,
  input logic [WORD_W-1:0] araddr,
  input logic              rvalid,
  input logic              rready,
  input logic [WORD_W-1:0] rdata,
  input logic [1:0]        rresp
);

  logic rbeat, second_q;
  assign rbeat = rvalid & rready;

  // Tracks whether the next good beat belongs to the second read
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                    second_q <= 1'b0;
    else if (start)                                second_q <= 1'b0;
    else if (rbeat && rresp == 2'b00 && !second_q) second_q <= 1'b1;
  end

  p_ar_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    arvalid && !arready |=> arvalid && $stable(araddr));

  p_one_outstanding_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(arvalid && rready));

  p_first_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> arvalid && araddr == $past(base) + $past(offset));

  p_chain_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rbeat && rresp == 2'b00 && !second_q |=> arvalid && araddr == $past(rdata));

  p_result_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rbeat && rresp == 2'b00 && second_q |=> result == $past(rdata) && done);

  p_error_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rbeat && rresp != 2'b00 |=> !arvalid && !rready && error && $stable(result));

  p_start_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy && !done && !error);

endmodule

bind ptrfetch_engine ptrfetch_engine_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(seq_start), .base(base_w), .offset(offset_w),
  .result(result_w), .busy(busy_w), .done(done_w), .error(error_w),
  .arvalid(m_arvalid), .arready(m_arready), .araddr(m_araddr),
  .rvalid(m_rvalid), .rready(m_rready), .rdata(m_rdata), .rresp(m_rresp)
);

// File: tb/ptrfetch_engine_test.sv
`timescale 1ns/1ps
module ptrfetch_engine_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  s_awaddr, s_araddr;
  logic        s_awvalid, s_wvalid, s_bready, s_arvalid, s_rready;
  logic [31:0] s_wdata;
  logic [3:0]  s_wstrb;
  logic        s_awready, s_wready, s_bvalid, s_arready, s_rvalid;
  logic [1:0]  s_bresp, s_rresp;
  logic [31:0] s_rdata;
  logic [3:0]  m_arid;
  logic [31:0] m_araddr, m_rdata;
  logic [7:0]  m_arlen;
  logic [2:0]  m_arsize;
  logic [1:0]  m_arburst, m_rresp;
  logic        m_arvalid, m_arready, m_rvalid, m_rready;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  ptrfetch_engine uut (
    .clk(clk), .rst_n(rst_n),
    .s_awaddr(s_awaddr), .s_awvalid(s_awvalid), .s_awready(s_awready),
    .s_wdata(s_wdata), .s_wstrb(s_wstrb), .s_wvalid(s_wvalid), .s_wready(s_wready),
    .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready),
    .s_araddr(s_araddr), .s_arvalid(s_arvalid), .s_arready(s_arready),
    .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rvalid(s_rvalid), .s_rready(s_rready),
    .m_arid(m_arid), .m_araddr(m_araddr), .m_arlen(m_arlen), .m_arsize(m_arsize),
    .m_arburst(m_arburst), .m_arvalid(m_arvalid), .m_arready(m_arready),
    .m_rdata(m_rdata), .m_rresp(m_rresp), .m_rvalid(m_rvalid), .m_rready(m_rready)
  );

  // Memory model and scoreboard state
  logic [31:0] mem [logic [31:0]];
  bit          bad [logic [31:0]];
  logic [31:0] exp_ar [$];
  logic [31:0] last_res = 32'h0;
  int          ar_dly = 0;
  int          r_dly  = 0;

  function automatic logic [31:0] mem_rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : (a ^ 32'hC3C3_0000);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Monitor and memory responder: pops expected read addresses as they appear
  initial begin
    int cnt = 0;
    int ph  = 0;
    logic [31:0] cur;
    m_arready = 1'b0; m_rvalid = 1'b0; m_rdata = '0; m_rresp = 2'b00;
    forever begin
      @(negedge clk);
      if (ph == 2) begin
        m_rvalid = 1'b0; ph = 0; cnt = 0;
      end else if (ph == 1) begin
        if (m_arready) chk("R6 no new AR while waiting, RREADY high",
                           {30'd0, m_arvalid, m_rready}, 32'd1);
        m_arready = 1'b0;
        if (cnt >= r_dly) begin
          m_rvalid = 1'b1;
          m_rdata  = mem_rd(cur);
          m_rresp  = bad.exists(cur) ? 2'b10 : 2'b00;
          ph = 2;
        end else cnt++;
      end else if (m_arvalid) begin
        if (cnt >= ar_dly) begin
          m_arready = 1'b1; cur = m_araddr; ph = 1; cnt = 0;
          if (exp_ar.size() == 0) begin
            chk("R5 unexpected master read", m_araddr, 32'hFFFF_FFFF);
          end else begin
            chk("R2/R3 read address", m_araddr, exp_ar.pop_front());
          end
          chk("R7 attributes", {15'd0, m_arlen, m_arsize, m_arburst, m_arid},
              {15'd0, 8'd0, 3'b010, 2'b01, 4'd0});
        end else cnt++;
      end
    end
  end

  task automatic lite_write(input logic [3:0] a, input logic [31:0] d, input logic [3:0] st);
    @(negedge clk);
    s_awaddr = a; s_wdata = d; s_wstrb = st; s_awvalid = 1'b1; s_wvalid = 1'b1;
    #1;
    while (!s_awready) begin @(negedge clk); #1; end
    @(negedge clk);
    s_awvalid = 1'b0; s_wvalid = 1'b0;
    while (!s_bvalid) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic lite_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    s_araddr = a; s_arvalid = 1'b1;
    #1;
    while (!s_arready) begin @(negedge clk); #1; end
    @(negedge clk);
    s_arvalid = 1'b0;
    while (!s_rvalid) @(negedge clk);
    d = s_rdata;
    @(negedge clk);
  endtask

  // Driver: predicts reads and outcome, pushes them, then launches
  task automatic launch(input logic [31:0] b, input logic [31:0] o,
                        output logic [31:0] res, output logic [31:0] st);
    logic [31:0] a1, p;
    a1 = b + o;
    exp_ar.push_back(a1);
    if (bad.exists(a1)) begin
      res = last_res; st = 32'd4;
    end else begin
      p = mem_rd(a1);
      exp_ar.push_back(p);
      if (bad.exists(p)) begin res = last_res; st = 32'd4; end
      else begin res = mem_rd(p); st = 32'd2; end
    end
    last_res = res;
    lite_write(4'h0, b, 4'hF);
    lite_write(4'h4, o, 4'hF);
  endtask

  task automatic finish_case(input string req, input logic [31:0] res, input logic [31:0] st);
    logic [31:0] v;
    int lim = 0;
    lite_read(4'hC, v);
    while (v[0] && lim < 200) begin lite_read(4'hC, v); lim++; end
    chk({req, " status"}, v, st);
    lite_read(4'h8, v);
    chk({req, " result"}, v, res);
    chk({req, " pending reads"}, exp_ar.size(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, er, es, keep;
    rst_n = 1'b0;
    s_awaddr = '0; s_araddr = '0; s_wdata = '0; s_wstrb = '0;
    s_awvalid = 0; s_wvalid = 0; s_arvalid = 0; s_bready = 1; s_rready = 1;
    repeat (3) @(negedge clk);
    // R10: outputs idle under reset
    chk("R10 outputs in reset", {28'd0, m_arvalid, m_rready, s_bvalid, s_rvalid}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      lite_read(4'(i * 4), v);
      chk("R10 register reset value", v, 32'd0);
    end

    // R1: readback, strobes, unaligned writes ignored
    lite_write(4'h0, 32'h1122_3344, 4'hF);
    lite_write(4'h0, 32'hAABB_CCDD, 4'b0101);
    lite_read(4'h0, v);
    chk("R1 byte strobes", v, 32'h11BB_33DD);
    lite_write(4'h1, 32'h5555_5555, 4'hF);
    lite_read(4'h0, v);
    chk("R1 unaligned write ignored", v, 32'h11BB_33DD);
    lite_read(4'h2, v);
    chk("R1 unaligned read returns zero", v, 32'd0);

    // R2 R3 R4: worked example, no bus delay
    mem[32'h0000_ABCD] = 32'h0000_0100;
    mem[32'h0000_0100] = 32'h0000_0005;
    launch(32'h0000_ABC0, 32'h0000_000D, er, es);
    finish_case("R4 example", er, es);
    lite_read(4'h4, v);
    chk("R1 offset readback", v, 32'h0000_000D);

    // R2: sum wraps modulo 2^32
    ar_dly = 2; r_dly = 3;
    mem[32'h0000_0014] = 32'h0000_2000;
    mem[32'h0000_2000] = 32'hDEAD_BEEF;
    launch(32'hFFFF_FFF0, 32'h0000_0024, er, es);
    finish_case("R2 wrap", er, es);

    // R6: various handshake delays, default memory contents
    for (int i = 0; i < 4; i++) begin
      ar_dly = i; r_dly = 3 - i;
      launch(32'h0010_0000 * (i + 1), 32'h40 + i * 4, er, es);
      finish_case("R6 delay sweep", er, es);
    end

    // R5 R9: offset write while busy stores but does not restart
    ar_dly = 10; r_dly = 1;
    launch(32'h0000_3000, 32'h0000_0008, er, es);
    lite_write(4'h4, 32'h0000_0777, 4'hF);
    lite_read(4'hC, v);
    chk("R9 busy set, done clear mid-run", v, 32'd1);
    finish_case("R5 no restart", er, es);
    lite_read(4'h4, v);
    chk("R5 offset stored while busy", v, 32'h0000_0777);
    ar_dly = 0; r_dly = 0;

    // R8: failure on first read
    bad[32'h0000_5000] = 1'b1;
    launch(32'h0000_5000, 32'h0, er, es);
    finish_case("R8 first read error", er, es);

    // R9: a clean run clears error
    launch(32'h0000_ABC0, 32'h0000_000D, er, es);
    finish_case("R9 error cleared", er, es);

    // R8: failure on second read
    mem[32'h0000_6000] = 32'h0000_7000;
    bad[32'h0000_7000] = 1'b1;
    launch(32'h0000_6000, 32'h0, er, es);
    finish_case("R8 second read error", er, es);

    // R4: result and status ignore writes
    lite_read(4'h8, keep);
    lite_write(4'h8, 32'h1234_5678, 4'hF);
    lite_write(4'hC, 32'h0000_0007, 4'hF);
    lite_read(4'h8, v);
    chk("R4 result write ignored", v, keep);
    lite_read(4'hC, v);
    chk("R4 status write ignored", v, 32'd4);
    repeat (5) @(negedge clk);
    chk("R5 no read after status write", exp_ar.size(), 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule